// File: doc/BRIEF.md
# Two-Wire Serial Byte Memory Target

This block is the target side of a two-wire serial bus, in front of a 256-byte memory. SCL and SDA are sampled with a fast system clock. The block finds START and STOP conditions and decodes the device address. It then takes a word address, accepts a capped burst of written bytes and streams read bytes for as long as the bus master keeps acknowledging. SDA is never driven high. The block only produces an enable that pulls the line low, and a pull-up outside the block supplies the high level.

Three static strap inputs give the block one of eight device addresses, so eight blocks can share one bus and span 2 KB. A mode input sets how many data bytes one write transaction may carry. A master can do a random read by writing a word address and then issuing a repeated START with a read address. A current-address read simply continues from where the last transfer left the pointer.

Top module: `i2c_eeprom_target`

## Requirements
- R1: The device address byte is sent MSB first. Bits 7..4 are 1010, bits 3..1 equal strap[2:0] and bit 0 selects the direction (1 = read). On a match, the block holds SDA low during the ninth clock.
- R2: A device address that does not match gets no acknowledge. After it, the block drives nothing and changes neither memory nor pointer until the next START.
- R3: A START (SDA falls while SCL is high) restarts address reception from any state, including the middle of a byte. A STOP (SDA rises while SCL is high) returns the block to idle with SDA released.
- R4: In a write, the first byte after the address loads the 8-bit pointer. Each later accepted byte is acknowledged and stored at the pointer, and the pointer then increments, wrapping from 255 to 0.
- R5: With page_mode = 0, at most 7 data bytes are accepted per transaction. The 8th gets no acknowledge and does not change memory.
- R6: With page_mode = 1, at most 8 data bytes are accepted per transaction. The 9th gets no acknowledge and does not change memory.
- R7: A read returns the byte at the pointer, MSB first, and then increments the pointer with wrap. Reading continues for as long as the master acknowledges. After a master NACK, SDA stays released until the next START.
- R8: sda_oe = 1 pulls SDA low. It is asserted only while SCL is low.
- R9: After reset, sda_oe is 0, the pointer is 0 and every memory byte is 0.
- R10: A repeated START with a read address, sent after a write that only set the word address, reads from that address.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock, much faster than SCL |
| rst_n | input | 1 | Active-low asynchronous reset |
| scl_i | input | 1 | Bus clock line as seen on the pad |
| sda_i | input | 1 | Bus data line as seen on the pad |
| sda_oe | output | 1 | 1 pulls the data line low |
| strap | input | 3 | Static device address select |
| page_mode | input | 1 | 0 = 7-byte write cap, 1 = 8-byte write cap |

## Verification
The bench writes bursts that stay inside the cap and bursts that run past it, in both modes. The first kind checks acknowledge and storage, and the second checks that the byte past the cap is refused and leaves memory untouched. Reads are tried three ways: right after reset, through a repeated START after a pointer write, and as a current-address continuation. These tell apart pointer loading, pointer advance across transactions and wrap at 255. A foreign strap value, a foreign device code, a START in the middle of a byte and a master NACK followed by further clocks separate proper resynchronisation from a block that keeps responding to stale state.

// File: rtl/ee_pkg.sv
package ee_pkg;
  localparam int EE_AW = 8;
  localparam int EE_BW = 8;

  typedef enum logic [3:0] {
    ST_IDLE, ST_DEV, ST_DEV_ACK, ST_WADDR, ST_WADDR_ACK,
    ST_WDATA, ST_WDATA_ACK, ST_TX, ST_MACK, ST_SKIP
  } ee_state_e;

  // device code in the top nibble, strap bits below, direction bit ignored
  function automatic logic addr_hit(input logic [EE_BW-1:0] b,
                                    input logic [3:0] code,
                                    input logic [2:0] sel);
    return b[EE_BW-1:1] == {code, sel};
  endfunction

  function automatic logic [EE_AW-1:0] ptr_step(input logic [EE_AW-1:0] p);
    return p + {{(EE_AW-1){1'b0}}, 1'b1};
  endfunction

  function automatic logic [7:0] burst_cap(input logic page,
                                           input int unsigned norm,
                                           input int unsigned pg);
    return page ? 8'(pg) : 8'(norm);
  endfunction
endpackage

// File: rtl/ee_line_sync.sv
module ee_line_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic scl_i,
  input  logic sda_i,
  output logic scl_s,
  output logic sda_s,
  output logic ev_start,
  output logic ev_stop,
  output logic ev_rise,
  output logic ev_fall
);
  localparam int LAST = STAGES + 1;

  // bit 1 = SCL, bit 0 = SDA; one extra stage keeps the previous sample
  logic [1:0] chain [0:LAST];
  logic scl_p, sda_p;

  assign chain[0] = {scl_i, sda_i};

  for (genvar g = 0; g < LAST; g++) begin : g_stage
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) chain[g+1] <= 2'b11;
      else        chain[g+1] <= chain[g];
    end
  end

  assign scl_s = chain[STAGES][1];
  assign sda_s = chain[STAGES][0];
  assign scl_p = chain[LAST][1];
  assign sda_p = chain[LAST][0];

  assign ev_start = scl_s & scl_p & sda_p & ~sda_s;
  assign ev_stop  = scl_s & scl_p & ~sda_p & sda_s;
  assign ev_rise  = scl_s & ~scl_p;
  assign ev_fall  = ~scl_s & scl_p;
endmodule

// File: rtl/ee_byte_store.sv
module ee_byte_store #(
  parameter int AW = 8,
  parameter int DW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          we,
  input  logic [AW-1:0] addr,
  input  logic [DW-1:0] wdata,
  output logic [DW-1:0] rdata
);
  localparam int DEPTH = 1 << AW;

  logic [DW-1:0] cells [DEPTH];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < DEPTH; i++) cells[i] <= '0;
    end else if (we) begin
      cells[addr] <= wdata;
    end
  end

  assign rdata = cells[addr];
endmodule

// File: rtl/ee_link_ctrl.sv
module ee_link_ctrl
  import ee_pkg::*;
#(
  parameter logic [3:0] DEV_CODE   = 4'b1010,
  parameter int         NORM_LIMIT = 7,
  parameter int         PAGE_LIMIT = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             sda_s,
  input  logic             ev_start,
  input  logic             ev_stop,
  input  logic             ev_rise,
  input  logic             ev_fall,
  input  logic [2:0]       strap,
  input  logic             page_mode,
  input  logic [EE_BW-1:0] rd_data,
  output logic             sda_oe,
  output logic             wr_en,
  output logic [EE_AW-1:0] ptr,
  output logic [EE_BW-1:0] wr_data,
  output ee_state_e        state
);
  localparam int BCW = $clog2(EE_BW + 1);
  localparam logic [BCW-1:0] FULL = BCW'(EE_BW);

  logic [BCW-1:0]   bit_cnt;
  logic [EE_BW-1:0] rx_sh;
  logic [EE_BW-2:0] tx_sh;
  logic [7:0]       wcnt;
  logic             is_read;
  logic             m_ack;
  logic             byte_in;
  logic             room;

  assign byte_in = ev_fall && (bit_cnt == FULL);
  assign room    = wcnt < burst_cap(page_mode, NORM_LIMIT, PAGE_LIMIT);
  assign wr_en   = (state == ST_WDATA) && byte_in && room;
  assign wr_data = rx_sh;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state   <= ST_IDLE;
      bit_cnt <= '0;
      rx_sh   <= '0;
      tx_sh   <= '0;
      wcnt    <= '0;
      is_read <= 1'b0;
      m_ack   <= 1'b0;
      sda_oe  <= 1'b0;
      ptr     <= '0;
    end else if (ev_start) begin
      state   <= ST_DEV;
      bit_cnt <= '0;
      wcnt    <= '0;
      sda_oe  <= 1'b0;
    end else if (ev_stop) begin
      state   <= ST_IDLE;
      sda_oe  <= 1'b0;
    end else begin
      unique case (state)
        ST_DEV, ST_WADDR, ST_WDATA: begin
          if (ev_rise && bit_cnt < FULL) begin
            rx_sh   <= {rx_sh[EE_BW-2:0], sda_s};
            bit_cnt <= bit_cnt + 1'b1;
          end else if (byte_in) begin
            if (state == ST_DEV) begin
              if (addr_hit(rx_sh, DEV_CODE, strap)) begin
                sda_oe  <= 1'b1;
                is_read <= rx_sh[0];
                state   <= ST_DEV_ACK;
              end else begin
                state   <= ST_SKIP;
              end
            end else if (state == ST_WADDR) begin
              ptr    <= rx_sh[EE_AW-1:0];
              sda_oe <= 1'b1;
              state  <= ST_WADDR_ACK;
            end else if (room) begin
              ptr    <= ptr_step(ptr);
              wcnt   <= wcnt + 8'd1;
              sda_oe <= 1'b1;
              state  <= ST_WDATA_ACK;
            end else begin
              state  <= ST_SKIP;
            end
          end
        end
        ST_DEV_ACK: begin
          if (ev_fall) begin
            if (is_read) begin
              tx_sh   <= rd_data[EE_BW-2:0];
              sda_oe  <= ~rd_data[EE_BW-1];
              ptr     <= ptr_step(ptr);
              bit_cnt <= BCW'(1);
              state   <= ST_TX;
            end else begin
              sda_oe  <= 1'b0;
              bit_cnt <= '0;
              state   <= ST_WADDR;
            end
          end
        end
        ST_WADDR_ACK, ST_WDATA_ACK: begin
          if (ev_fall) begin
            sda_oe  <= 1'b0;
            bit_cnt <= '0;
            state   <= ST_WDATA;
          end
        end
        ST_TX: begin
          if (ev_fall) begin
            if (bit_cnt < FULL) begin
              sda_oe  <= ~tx_sh[EE_BW-2];
              tx_sh   <= {tx_sh[EE_BW-3:0], 1'b0};
              bit_cnt <= bit_cnt + 1'b1;
            end else begin
              sda_oe  <= 1'b0;
              state   <= ST_MACK;
            end
          end
        end
        ST_MACK: begin
          if (ev_rise) begin
            m_ack <= ~sda_s;
          end else if (ev_fall) begin
            if (m_ack) begin
              tx_sh   <= rd_data[EE_BW-2:0];
              sda_oe  <= ~rd_data[EE_BW-1];
              ptr     <= ptr_step(ptr);
              bit_cnt <= BCW'(1);
              state   <= ST_TX;
            end else begin
              state   <= ST_SKIP;
            end
          end
        end
        default: ;
      endcase
    end
  end
endmodule

// File: rtl/i2c_eeprom_target.sv
module i2c_eeprom_target
  import ee_pkg::*;
#(
  parameter logic [3:0] DEV_CODE    = 4'b1010,
  parameter int         NORM_LIMIT  = 7,
  parameter int         PAGE_LIMIT  = 8,
  parameter int         SYNC_STAGES = 2
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       scl_i,
  input  logic       sda_i,
  output logic       sda_oe,
  input  logic [2:0] strap,
  input  logic       page_mode
);
  logic             scl_s, sda_s;
  logic             ev_start, ev_stop, ev_rise, ev_fall;
  logic             mem_we;
  logic [EE_AW-1:0] ptr;
  logic [EE_BW-1:0] mem_wdata, mem_rdata;
  ee_state_e        fsm_state;

  ee_line_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk(clk), .rst_n(rst_n), .scl_i(scl_i), .sda_i(sda_i),
    .scl_s(scl_s), .sda_s(sda_s),
    .ev_start(ev_start), .ev_stop(ev_stop),
    .ev_rise(ev_rise), .ev_fall(ev_fall)
  );

  ee_link_ctrl #(
    .DEV_CODE(DEV_CODE), .NORM_LIMIT(NORM_LIMIT), .PAGE_LIMIT(PAGE_LIMIT)
  ) u_ctrl (
    .clk(clk), .rst_n(rst_n), .sda_s(sda_s),
    .ev_start(ev_start), .ev_stop(ev_stop),
    .ev_rise(ev_rise), .ev_fall(ev_fall),
    .strap(strap), .page_mode(page_mode), .rd_data(mem_rdata),
    .sda_oe(sda_oe), .wr_en(mem_we), .ptr(ptr),
    .wr_data(mem_wdata), .state(fsm_state)
  );

  ee_byte_store #(.AW(EE_AW), .DW(EE_BW)) u_store (
    .clk(clk), .rst_n(rst_n), .we(mem_we), .addr(ptr),
    .wdata(mem_wdata), .rdata(mem_rdata)
  );
endmodule

// File: rtl/ee_target_chk.sv
module ee_target_chk
  import ee_pkg::*;
#(
  parameter int NORM_LIMIT = 7,
  parameter int PAGE_LIMIT = 8
) (
  input logic      clk,
  input logic      rst_n,
  input logic      ev_start,
  input logic      ev_stop,
  input logic      scl_s,
  input logic      sda_oe,
  input logic      mem_we,
  input logic      page_mode,
  input ee_state_e state
);
  logic [7:0] wr_seen;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)        wr_seen <= '0;
    else if (ev_start) wr_seen <= '0;
    else if (mem_we)   wr_seen <= wr_seen + 8'd1;
  end

  a_r3_start_restarts: assert property (@(posedge clk) disable iff (!rst_n)
    ev_start |=> state == ST_DEV);

  a_r3_stop_idles: assert property (@(posedge clk) disable iff (!rst_n)
    ev_stop |=> (state == ST_IDLE) && !sda_oe);

  a_r2_skip_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    state == ST_SKIP |-> !sda_oe);

  a_r8_pull_while_low: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(sda_oe) |-> !scl_s);

  // R5 and R6: the write counter since START stays under the active cap
  a_r5_burst_cap: assert property (@(posedge clk) disable iff (!rst_n)
    mem_we |-> wr_seen < (page_mode ? 8'(PAGE_LIMIT) : 8'(NORM_LIMIT)));
endmodule

bind i2c_eeprom_target ee_target_chk #(
  .NORM_LIMIT(NORM_LIMIT), .PAGE_LIMIT(PAGE_LIMIT)
) u_chk (
  .clk(clk), .rst_n(rst_n), .ev_start(ev_start), .ev_stop(ev_stop),
  .scl_s(scl_s), .sda_oe(sda_oe), .mem_we(mem_we),
  .page_mode(page_mode), .state(fsm_state)
);

// File: tb/i2c_eeprom_target_tb.sv
`timescale 1ns/1ps
module i2c_eeprom_target_tb;
  localparam int HALF = 20;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       scl = 1'b1;
  logic       sda_m = 1'b1;
  logic       page_mode = 1'b0;
  logic [2:0] strap = 3'b101;
  logic       sda_oe;
  logic       sda_bus;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;
  int mem_m [256];
  int ptr_m = 0;
  int mon_bad = 0;
  logic prev_oe = 1'b0;

  assign sda_bus = sda_m & ~sda_oe;

  always #2.5 clk = ~clk;

  i2c_eeprom_target u_dut (
    .clk(clk), .rst_n(rst_n), .scl_i(scl), .sda_i(sda_bus),
    .sda_oe(sda_oe), .strap(strap), .page_mode(page_mode)
  );

  // R8 monitor: the pull-down may only start while the bus clock is low
  always @(negedge clk) begin
    if (rst_n && sda_oe && !prev_oe && scl) mon_bad++;
    prev_oe <= sda_oe;
  end

  task automatic tick(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic bus_start();
    scl = 1'b0; tick(6); sda_m = 1'b1; tick(HALF-6);
    scl = 1'b1; tick(HALF/2); sda_m = 1'b0; tick(HALF/2);
  endtask

  task automatic bus_stop();
    scl = 1'b0; tick(6); sda_m = 1'b0; tick(HALF-6);
    scl = 1'b1; tick(HALF/2); sda_m = 1'b1; tick(HALF/2);
  endtask

  task automatic bit_put(input logic b);
    scl = 1'b0; tick(6); sda_m = b; tick(HALF-6);
    scl = 1'b1; tick(HALF);
  endtask

  task automatic bit_get(output logic b);
    scl = 1'b0; tick(6); sda_m = 1'b1; tick(HALF-6);
    scl = 1'b1; tick(HALF/2); b = sda_bus; tick(HALF/2);
  endtask

  task automatic put_byte(input logic [7:0] v, output bit acked);
    logic s;
    for (int i = 7; i >= 0; i--) bit_put(v[i]);
    bit_get(s);
    acked = !s;
  endtask

  task automatic get_byte(output logic [7:0] v, input bit give_ack);
    logic s;
    for (int i = 7; i >= 0; i--) begin
      bit_get(s);
      v[i] = s;
    end
    bit_put(!give_ack);
  endtask

  task automatic set_ptr(input int a);
    bit ak;
    bus_start();
    put_byte({4'b1010, strap, 1'b0}, ak);
    chk(ak, "R1 write address ack", int'(ak), 1);
    put_byte(8'(a), ak);
    chk(ak, "R4 word address ack", int'(ak), 1);
    ptr_m = a;
  endtask

  task automatic do_write(input int a, input int n, input int seed,
                          input bit pg, input string over_tag);
    bit ak;
    int cap;
    logic [7:0] v;
    page_mode = pg;
    cap = pg ? 8 : 7;
    set_ptr(a);
    for (int i = 0; i < n; i++) begin
      v = 8'((seed + i * 29) & 255);
      put_byte(v, ak);
      if (i < cap) chk(ak == 1'b1, "R4 data ack within cap", int'(ak), 1);
      else         chk(ak == 1'b0, over_tag, int'(ak), 0);
      if (!ak) break;
      mem_m[ptr_m] = int'(v);
      ptr_m = (ptr_m + 1) % 256;
    end
    bus_stop();
  endtask

  task automatic do_read(input int n, input string tag);
    bit ak;
    logic [7:0] v;
    bus_start();
    put_byte({4'b1010, strap, 1'b1}, ak);
    chk(ak, "R1 read address ack", int'(ak), 1);
    for (int i = 0; i < n; i++) begin
      get_byte(v, i < n - 1);
      chk(int'(v) == mem_m[ptr_m], tag, int'(v), mem_m[ptr_m]);
      ptr_m = (ptr_m + 1) % 256;
    end
    bus_stop();
  endtask

  initial begin
    for (int i = 0; i < 256; i++) mem_m[i] = 0;
    tick(5);
    rst_n = 1'b1;
    tick(4);
    chk(sda_oe == 1'b0, "R9 line released after reset", int'(sda_oe), 0);
    do_read(2, "R9 pointer and memory cleared");

    do_write(8'h10, 3, 8'h31, 1'b0, "R4 unexpected");
    set_ptr(8'h10);
    do_read(3, "R10 random read through repeated start");
    do_read(2, "R7 current address continues");

    do_write(8'h20, 8, 8'h55, 1'b0, "R5 eighth byte refused");
    set_ptr(8'h20);
    do_read(8, "R5 readback, eighth byte untouched");

    do_write(8'h40, 9, 8'h0f, 1'b1, "R6 ninth byte refused");
    set_ptr(8'h40);
    do_read(9, "R6 readback, ninth byte untouched");

    do_write(8'hFF, 2, 8'hc4, 1'b0, "R4 unexpected");
    set_ptr(8'hFF);
    do_read(3, "R7 read wraps 255 to 0");

    // R2: foreign strap and foreign device code
    begin
      bit ak;
      bus_start();
      put_byte({4'b1010, 3'b010, 1'b0}, ak);
      chk(!ak, "R2 foreign strap not acked", int'(ak), 0);
      put_byte(8'h00, ak);
      chk(!ak, "R2 following byte ignored", int'(ak), 0);
      bus_stop();
      bus_start();
      put_byte({4'b1011, strap, 1'b1}, ak);
      chk(!ak, "R2 foreign code not acked", int'(ak), 0);
      bus_stop();
      do_read(1, "R2 pointer untouched");
    end

    // R3: START in the middle of a byte, then a clean write
    begin
      bit ak;
      bus_start();
      put_byte({4'b1010, strap, 1'b0}, ak);
      bit_put(1'b1); bit_put(1'b0); bit_put(1'b1); bit_put(1'b1);
      bus_start();
      put_byte({4'b1010, strap, 1'b0}, ak);
      chk(ak, "R3 address acked after mid-byte START", int'(ak), 1);
      put_byte(8'h30, ak);
      chk(ak, "R3 word address acked", int'(ak), 1);
      put_byte(8'h99, ak);
      chk(ak, "R3 data acked", int'(ak), 1);
      mem_m[8'h30] = 8'h99;
      ptr_m = 8'h31;
      bus_stop();
      tick(4);
      chk(sda_oe == 1'b0, "R3 idle after STOP", int'(sda_oe), 0);
      set_ptr(8'h30);
      do_read(1, "R3 readback");
    end

    // R7: after a master NACK the line stays released
    begin
      bit ak;
      logic [7:0] v;
      logic s;
      int lows = 0;
      bus_start();
      put_byte({4'b1010, strap, 1'b1}, ak);
      chk(ak, "R1 read address ack", int'(ak), 1);
      get_byte(v, 1'b0);
      chk(int'(v) == mem_m[ptr_m], "R7 single byte read", int'(v), mem_m[ptr_m]);
      ptr_m = (ptr_m + 1) % 256;
      for (int i = 0; i < 9; i++) begin
        bit_get(s);
        if (!s) lows++;
      end
      chk(lows == 0, "R7 quiet after master NACK", lows, 0);
      bus_stop();
    end

    chk(mon_bad == 0, "R8 pull-down starts only with SCL low", mon_bad, 0);

    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (150000) @(negedge clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end
endmodule